// File: doc/BRIEF.md
# Misaligned Access Splitting Bus Sequencer

This block sits between a processor core and a 16-bit internal memory bus that is addressed by byte. The core issues one request at a time through a valid/ready handshake: a 24-bit byte address, a size code selecting an 8-, 16- or 32-bit transfer, a direction bit and up to 32 bits of write data. The sequencer turns that request into one to three bus cycles. Each cycle drives an address and a two-bit lane enable. The low lane (bus bits 7..0) carries the byte at the even address of a halfword pair and the high lane (bits 15..8) carries the byte at the odd address.

An access that starts on an odd address begins with a cycle that uses only the high lane. It continues with full-halfword cycles, and a single leftover byte is finished with a low-lane-only cycle. Data is little-endian: byte i of the request data belongs to address start+i. On writes each byte is steered onto its lane. On reads the returned lanes are gathered into the result. Each bus cycle lasts a fixed two clocks. A one-clock done pulse, with the assembled read data, follows the last cycle.

Top module: `split_bus_seq`

## Requirements
- R1: Bus bits 7..0 carry the byte at the even address of the addressed halfword pair and bits 15..8 the byte at the odd address; bus_be bit 0 enables the low lane and bit 1 the high lane.
- R2: Size code 0 (8-bit) makes one bus cycle at the start address, with bus_be = 01 when the address is even and 10 when it is odd.
- R3: Size code 1 (16-bit) at an even address makes one cycle at A with bus_be = 11; at an odd address it makes two cycles, A with 10 and then A+1 with 01.
- R4: Size code 2 (32-bit) at an even address makes cycles A (11) and A+2 (11); at an odd address it makes cycles A (10), A+1 (11) and A+3 (01).
- R5: Every bus cycle lasts exactly two clocks with address, lane enables and direction held. Cycles follow back to back, and the first starts in the clock after the request is accepted.
- R6: On a write, each enabled lane carries the request byte whose address it serves, and memory bytes outside the enabled lanes are left unchanged.
- R7: On a read, rdata byte i holds the byte read from address A+i, and the bytes beyond the access size read as zero.
- R8: done is a one-clock pulse in the clock after the last bus cycle ends. rdata is valid in that clock, and done is never high while a bus cycle is active.
- R9: req_ready is high only while no access is in progress, and a request presented while busy is not accepted.
- R10: Address, size, direction and write data are taken when the request is accepted. Later changes on those inputs do not affect the access.
- R11: Addresses of later cycles wrap modulo 2^24 (for example, a 32-bit access at FFFFFF uses FFFFFF, 000000, 000002).
- R12: After reset req_ready is 1, and done, bus_cyc and bus_be are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request may be taken |
| req_addr | input | 24 | Starting byte address |
| req_size | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, byte 0 for the start address |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Assembled read data, valid with done |
| bus_cyc | output | 1 | Bus cycle active |
| bus_addr | output | 24 | Byte address of the current cycle |
| bus_we | output | 1 | Current cycle is a write |
| bus_be | output | 2 | Lane enables, bit 0 low lane, bit 1 high lane |
| bus_wdata | output | 16 | Write lanes, zero on disabled lanes |
| bus_rdata | input | 16 | Read lanes, sampled at the end of each cycle |

## Verification
A wrong remaining-byte count shows at the ports as a missing or extra bus cycle within two clocks of where the split should have ended. The same fault shifts the done pulse by a multiple of two clocks. A wrong byte pointer puts the wrong request byte on a write lane in the very cycle it is used, and leaves a misplaced byte in rdata when done rises. A wrong phase count breaks the two-clock hold of the address at once. Random sizes, directions and odd or even addresses, together with accesses across the top of the address space, exercise each of these paths against a bench memory image.

// File: rtl/split_bus_pkg.sv
package split_bus_pkg;
   localparam int LANE_W = 8;
   localparam int LANES  = 2;
   localparam int BUS_W  = LANE_W * LANES;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } seq_state_t;

   localparam logic [LANES-1:0] EN_LOW  = 2'b01;
   localparam logic [LANES-1:0] EN_HIGH = 2'b10;
   localparam logic [LANES-1:0] EN_BOTH = 2'b11;
endpackage

// File: rtl/split_bus_plan.sv
module split_bus_plan
   import split_bus_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int CNT_W  = 3
)(
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [CNT_W-1:0]  remain,
   output logic [LANES-1:0]  lane_en,
   output logic [CNT_W-1:0]  step,
   output logic [ADDR_W-1:0] next_addr,
   output logic              last
);
   // odd address: high lane alone; one byte left: low lane alone; else both
   always_comb begin
      if (cur_addr[0])
         lane_en = EN_HIGH;
      else if (remain == CNT_W'(1))
         lane_en = EN_LOW;
      else
         lane_en = EN_BOTH;
   end

   assign step      = (lane_en == EN_BOTH) ? CNT_W'(2) : CNT_W'(1);
   assign next_addr = cur_addr + ADDR_W'(step);
   assign last      = (remain == step);
endmodule

// File: rtl/split_bus_wsteer.sv
module split_bus_wsteer
   import split_bus_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 3
)(
   input  logic [DATA_W-1:0] wdata,
   input  logic [CNT_W-1:0]  ptr,
   input  logic [LANES-1:0]  lane_en,
   output logic [BUS_W-1:0]  lanes
);
   localparam int MAX_BYTES = DATA_W / LANE_W;

   logic [CNT_W-1:0]  hi_idx;
   logic [LANE_W-1:0] lo_byte;
   logic [LANE_W-1:0] hi_byte;

   // the high lane takes the following byte only when both lanes move
   assign hi_idx = (lane_en == EN_BOTH) ? ptr + CNT_W'(1) : ptr;

   always_comb begin
      lo_byte = '0;
      hi_byte = '0;
      for (int b = 0; b < MAX_BYTES; b++) begin
         if (lane_en[0] && ptr == CNT_W'(b))
            lo_byte = wdata[b*LANE_W +: LANE_W];
         if (lane_en[1] && hi_idx == CNT_W'(b))
            hi_byte = wdata[b*LANE_W +: LANE_W];
      end
   end

   assign lanes = {hi_byte, lo_byte};
endmodule

// File: rtl/split_bus_rgather.sv
module split_bus_rgather
   import split_bus_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              capture,
   input  logic [CNT_W-1:0]  ptr,
   input  logic [LANES-1:0]  lane_en,
   input  logic [BUS_W-1:0]  lanes,
   output logic [DATA_W-1:0] acc
);
   localparam int MAX_BYTES = DATA_W / LANE_W;

   logic [CNT_W-1:0] hi_idx;
   assign hi_idx = (lane_en == EN_BOTH) ? ptr + CNT_W'(1) : ptr;

   for (genvar b = 0; b < MAX_BYTES; b++) begin : g_byte
      logic [LANE_W-1:0] q;
      logic take_lo, take_hi;
      assign take_lo = capture && lane_en[0] && (ptr == CNT_W'(b));
      assign take_hi = capture && lane_en[1] && (hi_idx == CNT_W'(b));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (clear)
            q <= '0;
         else if (take_lo)
            q <= lanes[LANE_W-1:0];
         else if (take_hi)
            q <= lanes[BUS_W-1:LANE_W];
      end

      // a byte slot is claimed by at most one lane per cycle
      always_comb begin
         if (rst_n)
            assert (!(take_lo && take_hi)) else $error("AST_ONE_LANE_PER_SLOT"); // R7
      end

      assign acc[b*LANE_W +: LANE_W] = q;
   end
endmodule

// File: rtl/split_bus_seq.sv
module split_bus_seq
   import split_bus_pkg::*;
#(
   parameter int ADDR_W   = 24,
   parameter int DATA_W   = 32,
   parameter int SIZE_W   = 2,
   parameter int BUS_CLKS = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [SIZE_W-1:0] req_size,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic              bus_cyc,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_we,
   output logic [LANES-1:0]  bus_be,
   output logic [BUS_W-1:0]  bus_wdata,
   input  logic [BUS_W-1:0]  bus_rdata
);
   localparam int MAX_BYTES = DATA_W / LANE_W;
   localparam int LOG_MAX   = $clog2(MAX_BYTES);
   localparam int CNT_W     = $clog2(MAX_BYTES + 1);
   localparam int PH_W      = (BUS_CLKS > 1) ? $clog2(BUS_CLKS) : 1;
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(BUS_CLKS - 1);

   // elaboration-time parameter checks
   if (DATA_W < BUS_W || (DATA_W % LANE_W) != 0 || (1 << LOG_MAX) != MAX_BYTES) begin : g_bad_data
      $error("split_bus_seq: DATA_W must be a power-of-two multiple of the bus width");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("split_bus_seq: ADDR_W too small");
   end
   if ((1 << SIZE_W) < LOG_MAX + 1) begin : g_bad_size
      $error("split_bus_seq: SIZE_W cannot encode every size");
   end
   if (BUS_CLKS < 1) begin : g_bad_clks
      $error("split_bus_seq: BUS_CLKS must be at least 1");
   end

   seq_state_t        state;
   logic [ADDR_W-1:0] cur_addr;
   logic [CNT_W-1:0]  remain;
   logic [CNT_W-1:0]  ptr;
   logic              is_wr;
   logic [DATA_W-1:0] wdata_q;
   logic [PH_W-1:0]   phase;
   logic              done_q;

   logic [CNT_W-1:0]  req_bytes;
   logic [LANES-1:0]  lane_en;
   logic [CNT_W-1:0]  step;
   logic [ADDR_W-1:0] next_addr;
   logic              last;
   logic [BUS_W-1:0]  steer_lanes;
   logic              accept;
   logic              running;
   logic              bus_end;

   // size code s selects 2**s bytes; codes past the widest clamp to it
   always_comb begin
      req_bytes = CNT_W'(MAX_BYTES);
      for (int s = 0; s <= LOG_MAX; s++)
         if (req_size == SIZE_W'(s))
            req_bytes = CNT_W'(1 << s);
   end

   assign running   = (state == ST_RUN);
   assign req_ready = (state == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign bus_end   = running && (phase == PH_LAST);

   split_bus_plan #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W)
   ) u_plan (
      .cur_addr  (cur_addr),
      .remain    (remain),
      .lane_en   (lane_en),
      .step      (step),
      .next_addr (next_addr),
      .last      (last)
   );

   split_bus_wsteer #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_wsteer (
      .wdata   (wdata_q),
      .ptr     (ptr),
      .lane_en (lane_en),
      .lanes   (steer_lanes)
   );

   split_bus_rgather #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_rgather (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (accept),
      .capture (bus_end && !is_wr),
      .ptr     (ptr),
      .lane_en (lane_en),
      .lanes   (bus_rdata),
      .acc     (rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cur_addr <= '0;
         remain   <= '0;
         ptr      <= '0;
         is_wr    <= 1'b0;
         wdata_q  <= '0;
         phase    <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            state    <= ST_RUN;
            cur_addr <= req_addr;
            remain   <= req_bytes;
            ptr      <= '0;
            is_wr    <= req_write;
            wdata_q  <= req_wdata;
            phase    <= '0;
         end else if (running) begin
            if (bus_end) begin
               phase    <= '0;
               cur_addr <= next_addr;
               remain   <= remain - step;
               ptr      <= ptr + step;
               if (last) begin
                  state  <= ST_IDLE;
                  done_q <= 1'b1;
               end
            end else begin
               phase <= phase + PH_W'(1);
            end
         end
      end
   end

   assign done      = done_q;
   assign bus_cyc   = running;
   assign bus_addr  = cur_addr;
   assign bus_we    = running && is_wr;
   assign bus_be    = running ? lane_en : '0;
   assign bus_wdata = (running && is_wr) ? steer_lanes : '0;

   // ---------------- assertions ----------------
   if (BUS_CLKS > 1) begin : g_hold_chk
      AST_CYCLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_cyc && phase != PH_LAST) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_be) && $stable(bus_we))); // R5
   end

   AST_ODD_HIGH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cyc && bus_addr[0]) |-> (bus_be == EN_HIGH)); // R4

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8

   AST_DONE_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !bus_cyc); // R8

   AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!bus_cyc && bus_be == '0)); // R9

   AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cyc && $past(bus_cyc) && !$past(req_ready)) |-> $stable(bus_we)); // R10
endmodule

// File: tb/split_bus_seq_test.sv
module split_bus_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [23:0] req_addr = '0;
   logic [1:0]  req_size = '0;
   logic        req_write = 1'b0;
   logic [31:0] req_wdata = '0;
   logic        done;
   logic [31:0] rdata;
   logic        bus_cyc;
   logic [23:0] bus_addr;
   logic        bus_we;
   logic [1:0]  bus_be;
   logic [15:0] bus_wdata;
   logic [15:0] bus_rdata;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc_cnt = 0;

   logic [7:0]  mem     [256];
   logic [7:0]  ref_mem [256];
   logic [23:0] exp_ad  [4];
   logic [1:0]  exp_be  [4];
   int          exp_n;

   split_bus_seq uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_size(req_size),
      .req_write(req_write), .req_wdata(req_wdata),
      .done(done), .rdata(rdata),
      .bus_cyc(bus_cyc), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   always #5 clk = ~clk;

   // memory model: low lane = even byte of the pair, high lane = odd byte (R1)
   assign bus_rdata = {mem[{bus_addr[7:1], 1'b1}], mem[{bus_addr[7:1], 1'b0}]};

   always @(posedge clk) begin
      cyc_cnt <= cyc_cnt + 1;
      if (cyc_cnt > 150000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog: got %0d cycles expected fewer", cyc_cnt);
         $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // expected cycle list from R2-R4 and R11
   task automatic plan_cycles(input logic [23:0] a, input int n);
      logic [23:0] cur = a;
      int left = n;
      exp_n = 0;
      if (cur[0]) begin
         exp_ad[exp_n] = cur; exp_be[exp_n] = 2'b10; exp_n++;
         cur = cur + 24'd1; left--;
      end
      while (left >= 2) begin
         exp_ad[exp_n] = cur; exp_be[exp_n] = 2'b11; exp_n++;
         cur = cur + 24'd2; left -= 2;
      end
      if (left == 1) begin
         exp_ad[exp_n] = cur; exp_be[exp_n] = 2'b01; exp_n++;
      end
   endtask

   task automatic run_req(input logic [23:0] a, input logic [1:0] sz, input bit we,
                          input logic [31:0] wd, input bit poke, input string ctag);
      int n = 1 << sz;
      logic [31:0] exp_rd = '0;
      plan_cycles(a, n);
      for (int i = 0; i < n; i++) begin
         if (we) ref_mem[8'(a + 24'(i))] = wd[i*8 +: 8];
         else    exp_rd[i*8 +: 8] = ref_mem[8'(a + 24'(i))];
      end
      @(negedge clk);
      chk(req_ready == 1'b1, "R9 ready when idle", 64'(req_ready), 64'(1));
      req_addr = a; req_size = sz; req_write = we; req_wdata = wd; req_valid = 1'b1;
      @(negedge clk);
      // R10: scramble the request fields after acceptance
      req_valid = 1'b0; req_addr = ~a; req_size = ~sz; req_write = ~we; req_wdata = ~wd;
      for (int k = 0; k < 2 * exp_n; k++) begin
         int c = k / 2;
         if (poke && k == 0) req_valid = 1'b1;      // R9: request while busy
         if (poke && k == 1) req_valid = 1'b0;
         chk(bus_cyc == 1'b1 && done == 1'b0 && req_ready == 1'b0,
             "R5/R8/R9 cycle active", 64'({bus_cyc, done, req_ready}), 64'(3'b100));
         chk(bus_addr == exp_ad[c], {ctag, " address"}, 64'(bus_addr), 64'(exp_ad[c]));
         chk(bus_be == exp_be[c], {"R1/", ctag, " lanes"}, 64'(bus_be), 64'(exp_be[c]));
         chk(bus_we == we, "R10 direction", 64'(bus_we), 64'(we));
         if (k % 2 == 1 && bus_we) begin
            if (bus_be[0]) mem[{bus_addr[7:1], 1'b0}] = bus_wdata[7:0];
            if (bus_be[1]) mem[{bus_addr[7:1], 1'b1}] = bus_wdata[15:8];
         end
         @(negedge clk);
      end
      chk(done == 1'b1 && bus_cyc == 1'b0, "R8 done after last cycle",
          64'({done, bus_cyc}), 64'(2'b10));
      if (!we) chk(rdata == exp_rd, "R7 R10 read data", 64'(rdata), 64'(exp_rd));
      else begin
         int bad = 0;
         for (int j = 0; j < 256; j++) if (mem[j] != ref_mem[j]) bad++;
         chk(bad == 0, "R6 R10 memory image", 64'(bad), 64'(0));
      end
      @(negedge clk);
      chk(done == 1'b0, "R8 single pulse", 64'(done), 64'(0));
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      for (int j = 0; j < 256; j++) begin
         mem[j] = 8'($urandom());
         ref_mem[j] = mem[j];
      end
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1 && done == 1'b0 && bus_cyc == 1'b0 && bus_be == 2'b00,
          "R12 in reset", 64'({req_ready, done, bus_cyc, bus_be}), 64'(5'b10000));
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1 && done == 1'b0 && bus_cyc == 1'b0 && bus_be == 2'b00,
          "R12 after reset", 64'({req_ready, done, bus_cyc, bus_be}), 64'(5'b10000));

      // directed corner cases
      run_req(24'h000010, 2'd0, 1'b0, 32'h0,         1'b0, "R2");
      run_req(24'h000011, 2'd0, 1'b1, 32'h000000A5,  1'b0, "R2");
      run_req(24'h000011, 2'd0, 1'b0, 32'h0,         1'b0, "R2");
      run_req(24'h000020, 2'd1, 1'b0, 32'h0,         1'b0, "R3");
      run_req(24'h000031, 2'd1, 1'b1, 32'h00005AC3,  1'b1, "R3");
      run_req(24'h000031, 2'd1, 1'b0, 32'h0,         1'b0, "R3");
      run_req(24'h000040, 2'd2, 1'b1, 32'h11223344,  1'b0, "R4");
      run_req(24'h000053, 2'd2, 1'b1, 32'hDEADBEEF,  1'b1, "R4");
      run_req(24'h000053, 2'd2, 1'b0, 32'h0,         1'b1, "R4");
      run_req(24'hFFFFFF, 2'd2, 1'b1, 32'hCAFEF00D,  1'b0, "R11");
      run_req(24'hFFFFFF, 2'd2, 1'b0, 32'h0,         1'b0, "R11");
      run_req(24'hFFFFFF, 2'd1, 1'b0, 32'h0,         1'b0, "R11");
      run_req(24'hFFFFFE, 2'd2, 1'b0, 32'h0,         1'b0, "R11");

      // constrained random mix
      for (int t = 0; t < 400; t++) begin
         logic [1:0] sz = 2'($urandom_range(0, 2));
         string tg = (sz == 2'd0) ? "R2" : (sz == 2'd1) ? "R3" : "R4";
         run_req(24'($urandom()), sz, 1'($urandom()), $urandom(), 1'($urandom()), tg);
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule